// File: doc/BRIEF.md
# Normalized Table-Interpolated Square Root

This unit turns a wide unsigned squared magnitude, such as the sum of the squares of an in-phase and a quadrature sample, into its integer square root. It keeps the full dynamic range of the operand without a bit-serial root. It accepts one operand on every clock and carries a sideband tag next to each operand. The tag is typically the sample address. The result leaves the pipe together with its own tag, so a downstream accumulator can index its memory without any extra alignment logic.

The operand is first zero-extended to an even width. It is then shifted left by an even count 2k until its top bit pair is non-zero, which places the mantissa in [0.25, 1). The upper mantissa bits address a small root table with a registered read. Two neighbouring entries come out of the table together. The remaining mantissa bits serve as the fraction for a straight-line blend between those two entries. Shifting the blended value right by k, plus the table's guard bits, undoes the normalization. With the default 33-bit operand the root is 17 bits wide, which is the width needed to reach floor(sqrt(2^33 - 1)) = 92681.

Top module: `mag_root`

## Requirements
- R1: While rst_ni is low, valid_o, root_o and tag_o are all zero, whatever valid_i does. After reset is released they stay zero until the first valid operand reaches the output.
- R2: An operand taken with valid_i high at a rising edge shows up with valid_o high exactly 5 rising edges later. Operands may arrive back to back on every cycle. A cycle with valid_i low gives a cycle with valid_o low 5 edges later.
- R3: tag_o carries the tag_i value that was presented with the operand whose root is on root_o.
- R4: For every operand x in [0, 2^IN_W - 1], root_o lies within ±1 of floor(sqrt(x)). This covers 1, perfect squares, powers of two and the maximum value. Any operand with non-zero normalized shift count 0 gives a root with its top bit set.
- R5: An operand of zero skips the table path and yields root_o = 0, with valid_o high.
- R6: Every non-zero operand is normalized by an even left shift so that the top two bits of the even-width operand are not both zero.
- R7: Root-table entries do not decrease with address. The entry one past the last address holds full scale. Each blended value lies between the two entries it was formed from.
- R8: While valid_o is low, root_o and tag_o keep the value of the last valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand on x_i is valid this cycle |
| x_i | input | IN_W (33) | Unsigned squared magnitude |
| tag_i | input | TAG_W (8) | Sideband tag carried with the operand |
| valid_o | output | 1 | root_o and tag_o hold a new result |
| root_o | output | (IN_W+1)/2 (17) | Integer square root of the operand |
| tag_o | output | TAG_W (8) | Tag that entered with the operand |

## Verification
The assertions assume that x_i and tag_i are settled before every rising edge on which valid_i is high. They also assume that reset is released between edges, so every stage register holds a defined value before a property is evaluated. The bench drives all inputs on the falling edge and releases reset there as well. It also sets valid_i to a known level from time zero. The operand stream spans the full input width: a directed table of corner values is followed by pseudo-random values whose bit length steps through every size from 1 to 33. This makes every normalization count, and zero, occur while the assertions are active.

// File: rtl/mag_root_pkg.sv
package mag_root_pkg;

  // floor(sqrt(v)) by bit-wise trial, used only for table initialization
  function automatic logic [31:0] isqrt_u64(input logic [63:0] v);
    logic [31:0] r;
    logic [31:0] t;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      t = r | (32'd1 << i);
      if ({32'd0, t} * {32'd0, t} <= v) r = t;
    end
    return r;
  endfunction

endpackage

// File: rtl/mag_root_norm.sv
module mag_root_norm #(
  parameter int W   = 34,
  parameter int K_W = 5
) (
  input  logic [W-1:0]   x_i,
  output logic [W-1:0]   m_o,
  output logic [K_W-1:0] k_o,
  output logic           zero_o
);
  localparam int P = W / 2;

  // count leading all-zero bit pairs
  always_comb begin
    k_o    = '0;
    zero_o = 1'b1;
    for (int j = P - 1; j >= 0; j--) begin
      if (zero_o) begin
        if (x_i[2*j+1 -: 2] != 2'b00) zero_o = 1'b0;
        else                          k_o    = k_o + K_W'(1);
      end
    end
    m_o = x_i << (2 * k_o);
  end

endmodule

// File: rtl/mag_root_rom.sv
module mag_root_rom
  import mag_root_pkg::*;
#(
  parameter int A_W   = 9,
  parameter int OUT_W = 17,
  parameter int G     = 8,
  parameter int T_W   = OUT_W + G + 1
) (
  input  logic           clk_i,
  input  logic [A_W-1:0] addr_i,
  output logic [T_W-1:0] base_o,
  output logic [T_W-1:0] next_o
);
  localparam int N  = (1 << A_W) + 1;
  localparam int SH = 2 * (OUT_W + G) - A_W;

  logic [T_W-1:0] tbl [N];
  logic [A_W:0]   addr_lo;
  logic [A_W:0]   addr_hi;

  // entry i = sqrt(i / 2^A_W) scaled to 2^(OUT_W+G); one extra entry at the top
  initial begin
    for (int i = 0; i < N; i++) tbl[i] = T_W'(isqrt_u64(64'(i) << SH));
  end

  assign addr_lo = {1'b0, addr_i};
  assign addr_hi = addr_lo + 1'b1;

  always_ff @(posedge clk_i) begin
    base_o <= tbl[addr_lo];
    next_o <= tbl[addr_hi];
  end

endmodule

// File: rtl/mag_root_lerp.sv
module mag_root_lerp #(
  parameter int T_W = 26,
  parameter int F_W = 25
) (
  input  logic [T_W-1:0] base_i,
  input  logic [T_W-1:0] next_i,
  input  logic [F_W-1:0] frac_i,
  output logic [T_W-1:0] v_o
);
  logic [T_W-1:0]     diff;
  logic [T_W+F_W-1:0] prod;

  always_comb begin
    diff = next_i - base_i;
    prod = diff * frac_i;
    v_o  = base_i + T_W'(prod >> F_W);
  end

endmodule

// File: rtl/mag_root.sv
module mag_root #(
  parameter int IN_W  = 33,
  parameter int TAG_W = 8,
  parameter int A_W   = 9,
  parameter int G     = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [IN_W-1:0]         x_i,
  input  logic [TAG_W-1:0]        tag_i,
  output logic                    valid_o,
  output logic [(IN_W+1)/2-1:0]   root_o,
  output logic [TAG_W-1:0]        tag_o
);
  localparam int OUT_W = (IN_W + 1) / 2;
  localparam int W     = 2 * OUT_W;
  localparam int K_W   = $clog2(OUT_W + 1);
  localparam int T_W   = OUT_W + G + 1;
  localparam int F_W   = W - A_W;

  // stage 1: input register
  logic             s1_valid;
  logic [W-1:0]     s1_x;
  logic [TAG_W-1:0] s1_tag;
  // stage 2: normalized
  logic             s2_valid, s2_zero;
  logic [W-1:0]     s2_m;
  logic [K_W-1:0]   s2_k;
  logic [TAG_W-1:0] s2_tag;
  // stage 3: table read
  logic             s3_valid, s3_zero;
  logic [F_W-1:0]   s3_frac;
  logic [K_W-1:0]   s3_k;
  logic [TAG_W-1:0] s3_tag;
  // stage 4: blended
  logic             s4_valid, s4_zero;
  logic [T_W-1:0]   s4_v;
  logic [K_W-1:0]   s4_k;
  logic [TAG_W-1:0] s4_tag;

  logic [W-1:0]     norm_m;
  logic [K_W-1:0]   norm_k;
  logic             norm_zero;
  logic [T_W-1:0]   rom_base, rom_next, lerp_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0; s1_x <= '0; s1_tag <= '0;
    end else begin
      s1_valid <= valid_i;
      s1_x     <= W'(x_i);
      s1_tag   <= tag_i;
    end
  end

  mag_root_norm #(.W(W), .K_W(K_W)) u_norm (
    .x_i(s1_x), .m_o(norm_m), .k_o(norm_k), .zero_o(norm_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid <= 1'b0; s2_zero <= 1'b1; s2_m <= '0; s2_k <= '0; s2_tag <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_zero  <= norm_zero;
      s2_m     <= norm_m;
      s2_k     <= norm_k;
      s2_tag   <= s1_tag;
    end
  end

  mag_root_rom #(.A_W(A_W), .OUT_W(OUT_W), .G(G), .T_W(T_W)) u_rom (
    .clk_i(clk_i), .addr_i(s2_m[W-1 -: A_W]), .base_o(rom_base), .next_o(rom_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s3_valid <= 1'b0; s3_zero <= 1'b1; s3_frac <= '0; s3_k <= '0; s3_tag <= '0;
    end else begin
      s3_valid <= s2_valid;
      s3_zero  <= s2_zero;
      s3_frac  <= s2_m[F_W-1:0];
      s3_k     <= s2_k;
      s3_tag   <= s2_tag;
    end
  end

  mag_root_lerp #(.T_W(T_W), .F_W(F_W)) u_lerp (
    .base_i(rom_base), .next_i(rom_next), .frac_i(s3_frac), .v_o(lerp_v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s4_valid <= 1'b0; s4_zero <= 1'b1; s4_v <= '0; s4_k <= '0; s4_tag <= '0;
    end else begin
      s4_valid <= s3_valid;
      s4_zero  <= s3_zero;
      s4_v     <= lerp_v;
      s4_k     <= s3_k;
      s4_tag   <= s3_tag;
    end
  end

  // output: undo normalization, hold last result when idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0; root_o <= '0; tag_o <= '0;
    end else begin
      valid_o <= s4_valid;
      if (s4_valid) begin
        root_o <= s4_zero ? '0 : OUT_W'(s4_v >> (G + s4_k));
        tag_o  <= s4_tag;
      end
    end
  end

  p_norm_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_valid && !s2_zero) |-> (s2_m[W-1 -: 2] != 2'b00));

  p_table_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s3_valid && !s3_zero) |-> (rom_base <= rom_next));

  p_blend_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s3_valid && !s3_zero) |-> (lerp_v >= rom_base && lerp_v <= rom_next));

  p_zero_root_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s4_valid && s4_zero) |=> (valid_o && root_o == '0));

  p_top_octave_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s4_valid && !s4_zero && s4_k == '0) |=> root_o[OUT_W-1]);

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s4_valid |=> (!valid_o && $stable(root_o) && $stable(tag_o)));

endmodule

// File: tb/sim_mag_root.sv
module sim_mag_root;
  localparam int IN_W  = 33;
  localparam int OUT_W = 17;
  localparam int TAG_W = 8;
  localparam int LAT   = 5;
  localparam int N_VEC = 17;
  localparam int N_ALL = N_VEC + 1500;

  localparam logic [IN_W-1:0] VEC_X [N_VEC] = '{
    33'd0, 33'd1, 33'd2, 33'd3, 33'd4, 33'd15, 33'd16, 33'd99, 33'd100,
    33'd65535, 33'd65536, 33'd1000000, 33'd123456789, 33'd4294967295,
    33'd4294967296, 33'd8000000000, 33'd8589934591};
  localparam logic [OUT_W-1:0] VEC_R [N_VEC] = '{
    17'd0, 17'd1, 17'd1, 17'd1, 17'd2, 17'd3, 17'd4, 17'd9, 17'd10,
    17'd255, 17'd256, 17'd1000, 17'd11111, 17'd65535,
    17'd65536, 17'd89442, 17'd92681};

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic [IN_W-1:0]  x_i = '0;
  logic [TAG_W-1:0] tag_i = '0;
  logic             valid_o;
  logic [OUT_W-1:0] root_o;
  logic [TAG_W-1:0] tag_o;

  int n_chk = 0;
  int n_err = 0;
  logic [IN_W-1:0]  sx [N_ALL];
  logic [OUT_W-1:0] sr [N_ALL];

  always #4 clk = ~clk;

  mag_root u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i), .tag_i(tag_i),
    .valid_o(valid_o), .root_o(root_o), .tag_o(tag_o)
  );

  function automatic longint unsigned fsqrt(input longint unsigned v);
    longint unsigned lo, hi, mid;
    lo = 0; hi = 64'd1 << 17;
    while (lo < hi) begin
      mid = (lo + hi + 1) / 2;
      if (mid * mid <= v) lo = mid; else hi = mid - 1;
    end
    return lo;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input int idx);
    longint d;
    d = longint'(root_o) - longint'(sr[idx]);
    chk(valid_o == 1'b1, "R2 valid after latency", longint'(valid_o), 1);
    chk(tag_o == TAG_W'(idx), "R3 tag alignment", longint'(tag_o), longint'(TAG_W'(idx)));
    if (sx[idx] == '0)
      chk(root_o == '0, "R5 zero operand", longint'(root_o), 0);
    else
      chk(d >= -1 && d <= 1, "R4 root within 1 LSB", longint'(root_o), longint'(sr[idx]));
  endtask

  initial begin
    longint unsigned lfsr;
    lfsr = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < N_ALL; i++) begin
      if (i < N_VEC) begin
        sx[i] = VEC_X[i];
        sr[i] = VEC_R[i];
      end else begin
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 7);
        lfsr = lfsr ^ (lfsr << 17);
        sx[i] = IN_W'(lfsr & ((64'd1 << (1 + (i % IN_W))) - 1));
        sr[i] = OUT_W'(fsqrt(64'(sx[i])));
      end
    end

    // R1: reset holds outputs at zero even with activity on the inputs
    valid_i = 1'b1; x_i = 33'd12345; tag_i = 8'h5A;
    repeat (6) @(negedge clk);
    chk(valid_o == 1'b0, "R1 valid in reset", longint'(valid_o), 0);
    chk(root_o == '0, "R1 root in reset", longint'(root_o), 0);
    chk(tag_o == '0, "R1 tag in reset", longint'(tag_o), 0);
    valid_i = 1'b0;
    rst_ni = 1'b1;

    // R2/R3/R4/R5: back-to-back stream, vectors then sweep
    for (int c = 0; c < N_ALL + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) chk_out(c - LAT);
      else begin
        chk(valid_o == 1'b0, "R1 idle after reset", longint'(valid_o), 0);
        chk(root_o == '0, "R1 root after reset", longint'(root_o), 0);
      end
      if (c < N_ALL) begin
        valid_i = 1'b1; x_i = sx[c]; tag_i = TAG_W'(c);
      end else begin
        valid_i = 1'b0;
      end
    end

    // R2: single operand, exact latency
    @(negedge clk);
    valid_i = 1'b1; x_i = 33'd49; tag_i = 8'hA5;
    @(negedge clk);
    valid_i = 1'b0; x_i = 33'd7777777;
    for (int c = 1; c < LAT; c++) begin
      chk(valid_o == 1'b0, "R2 no early valid", longint'(valid_o), 0);
      @(negedge clk);
    end
    chk(valid_o == 1'b1, "R2 valid at latency", longint'(valid_o), 1);
    chk(root_o == 17'd7, "R4 perfect square 49", longint'(root_o), 7);
    chk(tag_o == 8'hA5, "R3 single tag", longint'(tag_o), 8'hA5);

    // R8: idle cycles keep the last result
    tag_i = 8'h3C;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      x_i = IN_W'(c * 1000003);
      chk(valid_o == 1'b0, "R8 valid low when idle", longint'(valid_o), 0);
      chk(root_o == 17'd7, "R8 root held", longint'(root_o), 7);
      chk(tag_o == 8'hA5, "R8 tag held", longint'(tag_o), 8'hA5);
    end

    // R1: asynchronous reset clears held outputs at once
    rst_ni = 1'b0;
    #1;
    chk(root_o == '0, "R1 async reset root", longint'(root_o), 0);
    chk(tag_o == '0, "R1 async reset tag", longint'(tag_o), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule